// File: doc/BRIEF.md
# Daylight Saving Time Adjuster

This block sits next to a BCD calendar and decides when the clock must jump one hour forward in spring and one hour back in autumn. It holds eight configuration bytes: four that describe the spring rule (month, week/weekday selector, date, hour) and four that describe the autumn rule. The spring month byte also carries the global enable. A status output, `dst_active`, tells whether the clock is currently running on shifted time.

Each rule names either a fixed date or the Nth weekday of the month (N = 1..5, or 7 for the last such weekday). The choice is made by a priority bit in the rule's day byte. The block checks the rules only on a second-boundary pulse where the calendar's minutes and seconds both read 00. When the spring rule matches and the clock is not shifted, it raises a one-cycle `adj_fwd` request. When the autumn rule matches and the clock is shifted, it raises a one-cycle `adj_rev` request. The calendar counters act on these requests. Because the status bit gates each event, the repeated hour after a fall-back cannot trigger a second fall-back.

A small state machine sequences the requests. `ST_IDLE` waits for a qualifying tick. The transition `go_fwd` leads to `ST_FWD`, and the transition `go_rev` leads to `ST_REV`. Each of these states lasts exactly one cycle and drives its request, then takes `done` back to `ST_IDLE`. Ticks that arrive outside `ST_IDLE` are ignored.

Top module: `dst_adjuster`

## Requirements
- R1: After reset the configuration bytes read back as: addr0 04h, addr1 00h, addr2 01h, addr3 02h, addr4 10h, addr5 00h, addr6 01h, addr7 02h. `dst_active`, `adj_fwd` and `adj_rev` are 0.
- R2: Stored bits are limited to these read masks: addr0 9Fh, addr4 1Fh, addr1/addr5 7Fh, addr2/addr6 3Fh, addr3/addr7 BFh. Unused bits read 0. `cfg_rdata` follows `cfg_addr` combinationally.
- R3: With enable (addr0 bit 7) at 0, no request is raised. A write to addr0 with bit 7 = 0 clears `dst_active` at that clock edge.
- R4: The spring rule matches when: month bits 4:0 equal the calendar month, the day condition holds, and the hour byte matches. If the spring rule matches on a qualifying tick while `dst_active` is 0, then in the cycle after the tick `adj_fwd` is 1 for exactly one cycle and `dst_active` becomes 1.
- R5: The autumn rule (addr4..addr7) is matched in the same way. If it matches while `dst_active` is 1, then `adj_rev` pulses for one cycle and `dst_active` becomes 0. While `dst_active` is 0, an autumn match does nothing.
- R6: While `dst_active` is 1, a spring match does nothing.
- R7: When the day byte's bit 6 is 1, the day condition is: weekday field bits 2:0 equal the calendar weekday, and the week field bits 5:3 equal ((date-1)/7)+1. The date byte is then ignored. When bit 6 is 0, the day condition is: date byte bits 5:0 equal the calendar date.
- R8: A week field of 7 means the last such weekday. It holds when date+7 exceeds the days in the current month. February has 29 days when the BCD year is divisible by 4 (00 included) and 28 otherwise.
- R9: A week field of 0 or 6 in weekday mode never matches.
- R10: The hour byte matches only when its bit 7 (24-hour flag) equals calendar hour bit 7 and bits 5:0 are equal.
- R11: Rules are evaluated only in a cycle where `sec_tick` is 1 and both minutes and seconds are 00h. Otherwise no request is raised.
- R12: No request may cause a date rollover. A spring request is suppressed at 23h (24-hour) or 11 PM (31h, 12-hour with bit 5 = PM). An autumn request is suppressed at 00h (24-hour) or 12 AM (12h, 12-hour).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 3 | Configuration byte address 0..7 |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data for `cfg_addr`, masked |
| cal_year | input | 8 | Calendar year, BCD 00..99 |
| cal_month | input | 8 | Calendar month, BCD 01..12 |
| cal_date | input | 8 | Calendar date, BCD 01..31 |
| cal_wday | input | 3 | Calendar weekday 0..6 |
| cal_hour | input | 8 | Calendar hour: bit 7 = 24-hour flag; BCD in bits 5:0 (bit 5 = PM in 12-hour) |
| cal_min | input | 8 | Calendar minutes, BCD |
| cal_sec | input | 8 | Calendar seconds, BCD |
| sec_tick | input | 1 | One-cycle pulse at each second boundary |
| adj_fwd | output | 1 | Request: add one hour |
| adj_rev | output | 1 | Request: subtract one hour |
| dst_active | output | 1 | Clock currently shifted forward |

## Verification
The bench uses rules that should not fire. These include a date-mode byte that would match while weekday priority is set, week 2 tested on dates that fall in weeks 1 and 3, and the last-weekday rule on 22 February in leap and non-leap years. A design that computed week of month or month length wrongly would then fire on the wrong day or miss the right one. The bench repeats the autumn hour after a fall-back, to catch a design that ignores the status bit and would fall back twice. It also runs the spring rule at 23h or 11 PM and the autumn rule at midnight, where a design without the rollover guard would request a date-crossing jump. Mismatched 12-hour and 24-hour flags, as well as non-zero minutes or seconds, must stay silent. Clearing the enable must drop the status at once.

// File: rtl/dst_pkg.sv
package dst_pkg;

    localparam int RULES          = 2;
    localparam int BYTES_PER_RULE = 4;
    localparam int NUM_REGS       = RULES * BYTES_PER_RULE;
    localparam int CFG_ADDR_W     = $clog2(NUM_REGS);
    localparam int ENA_BIT        = 7;
    localparam int PRIO_BIT       = 6;
    localparam logic [2:0] WK_LAST    = 3'd7;
    localparam logic [2:0] WK_INVALID = 3'd6;

    // byte slots inside one rule
    localparam int SLOT_MONTH = 0;
    localparam int SLOT_DAY   = 1;
    localparam int SLOT_DATE  = 2;
    localparam int SLOT_HOUR  = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_REV  = 2'd2
    } adj_state_e;

    function automatic logic [7:0] reg_default(input int idx);
        case (idx % BYTES_PER_RULE)
            SLOT_MONTH: reg_default = (idx < BYTES_PER_RULE) ? 8'h04 : 8'h10;
            SLOT_DAY:   reg_default = 8'h00;
            SLOT_DATE:  reg_default = 8'h01;
            default:    reg_default = 8'h02;
        endcase
    endfunction

    function automatic logic [7:0] reg_mask(input int idx);
        case (idx % BYTES_PER_RULE)
            SLOT_MONTH: reg_mask = (idx == 0) ? 8'h9F : 8'h1F;
            SLOT_DAY:   reg_mask = 8'h7F;
            SLOT_DATE:  reg_mask = 8'h3F;
            default:    reg_mask = 8'hBF;
        endcase
    endfunction

    function automatic logic [7:0] bcd_to_bin(input logic [7:0] bcd);
        bcd_to_bin = ({4'b0, bcd[7:4]} * 8'd10) + {4'b0, bcd[3:0]};
    endfunction

    function automatic logic [4:0] month_days(input logic [7:0] mon_bin,
                                              input logic [7:0] yr_bin);
        case (mon_bin)
            8'd2:                     month_days = (yr_bin[1:0] == 2'b00) ? 5'd29 : 5'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  month_days = 5'd30;
            default:                  month_days = 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/dst_cfg_regs.sv
module dst_cfg_regs
    import dst_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CFG_ADDR_W-1:0] addr,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic [NUM_REGS*8-1:0] regs_flat,
    output logic                  enable,
    output logic                  ena_clear
);

    logic [7:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[i] <= reg_default(i);
            end else if (wr_en && (addr == CFG_ADDR_W'(i))) begin
                regs[i] <= wdata & reg_mask(i);
            end
        end
        assign regs_flat[i*8 +: 8] = regs[i];
    end

    assign rdata     = regs[addr];
    assign enable    = regs[0][ENA_BIT];
    assign ena_clear = wr_en && (addr == '0) && !wdata[ENA_BIT];

endmodule

// File: rtl/dst_cal_decode.sv
module dst_cal_decode
    import dst_pkg::*;
(
    input  logic [7:0] cal_year,
    input  logic [7:0] cal_month,
    input  logic [7:0] cal_date,
    output logic [2:0] week_of_month,
    output logic       last_week
);

    logic [7:0] date_bin;
    logic [7:0] mon_bin;
    logic [7:0] yr_bin;
    logic [4:0] dim;
    logic [7:0] wom_full;

    always_comb begin
        date_bin = bcd_to_bin(cal_date);
        mon_bin  = bcd_to_bin(cal_month);
        yr_bin   = bcd_to_bin(cal_year);
        dim      = month_days(mon_bin, yr_bin);
        if (date_bin == 8'd0) begin
            wom_full = 8'd0;
        end else begin
            wom_full = ((date_bin - 8'd1) / 8'd7) + 8'd1;
        end
        week_of_month = wom_full[2:0];
        last_week     = (date_bin + 8'd7) > {3'b0, dim};
    end

endmodule

// File: rtl/dst_rule_match.sv
module dst_rule_match
    import dst_pkg::*;
(
    input  logic [7:0] rule_month,
    input  logic [7:0] rule_day,
    input  logic [7:0] rule_date,
    input  logic [7:0] rule_hour,
    input  logic [7:0] cal_month,
    input  logic [7:0] cal_date,
    input  logic [2:0] cal_wday,
    input  logic [7:0] cal_hour,
    input  logic [2:0] week_of_month,
    input  logic       last_week,
    output logic       match
);

    logic [2:0] wk_sel;
    logic       month_ok;
    logic       week_ok;
    logic       day_ok;
    logic       hour_ok;

    always_comb begin
        wk_sel   = rule_day[5:3];
        month_ok = (rule_month[4:0] == cal_month[4:0]);
        if (wk_sel == WK_LAST) begin
            week_ok = last_week;
        end else if ((wk_sel == 3'd0) || (wk_sel == WK_INVALID)) begin
            week_ok = 1'b0;
        end else begin
            week_ok = (wk_sel == week_of_month);
        end
        if (rule_day[PRIO_BIT]) begin
            day_ok = week_ok && (rule_day[2:0] == cal_wday);
        end else begin
            day_ok = (rule_date[5:0] == cal_date[5:0]);
        end
        hour_ok = (rule_hour[7] == cal_hour[7]) && (rule_hour[5:0] == cal_hour[5:0]);
        match   = month_ok && day_ok && hour_ok;
    end

endmodule

// File: rtl/dst_adjuster.sv
module dst_adjuster
    import dst_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cfg_wr_en,
    input  logic [CFG_ADDR_W-1:0] cfg_addr,
    input  logic [7:0]            cfg_wdata,
    output logic [7:0]            cfg_rdata,
    input  logic [7:0]            cal_year,
    input  logic [7:0]            cal_month,
    input  logic [7:0]            cal_date,
    input  logic [2:0]            cal_wday,
    input  logic [7:0]            cal_hour,
    input  logic [7:0]            cal_min,
    input  logic [7:0]            cal_sec,
    input  logic                  sec_tick,
    output logic                  adj_fwd,
    output logic                  adj_rev,
    output logic                  dst_active
);

    localparam int FWD_IDX = 0;
    localparam int REV_IDX = 1;

    logic [NUM_REGS*8-1:0] regs_flat;
    logic                  enable;
    logic                  ena_clear;
    logic [2:0]            week_of_month;
    logic                  last_week;
    logic [RULES-1:0]      rule_hit;

    adj_state_e state_q;
    adj_state_e state_d;

    logic top_of_hour;
    logic last_hour;
    logic first_hour;
    logic go_fwd;
    logic go_rev;
    logic status_q;

    dst_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_wr_en),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .regs_flat (regs_flat),
        .enable    (enable),
        .ena_clear (ena_clear)
    );

    dst_cal_decode u_decode (
        .cal_year      (cal_year),
        .cal_month     (cal_month),
        .cal_date      (cal_date),
        .week_of_month (week_of_month),
        .last_week     (last_week)
    );

    for (genvar r = 0; r < RULES; r++) begin : g_rule
        localparam int BASE = r * BYTES_PER_RULE * 8;
        dst_rule_match u_match (
            .rule_month    (regs_flat[BASE + SLOT_MONTH*8 +: 8]),
            .rule_day      (regs_flat[BASE + SLOT_DAY*8   +: 8]),
            .rule_date     (regs_flat[BASE + SLOT_DATE*8  +: 8]),
            .rule_hour     (regs_flat[BASE + SLOT_HOUR*8  +: 8]),
            .cal_month     (cal_month),
            .cal_date      (cal_date),
            .cal_wday      (cal_wday),
            .cal_hour      (cal_hour),
            .week_of_month (week_of_month),
            .last_week     (last_week),
            .match         (rule_hit[r])
        );
    end

    // Hour-edge guards keep a jump inside the current day.
    always_comb begin
        top_of_hour = sec_tick && (cal_min == 8'h00) && (cal_sec == 8'h00);
        if (cal_hour[7]) begin
            last_hour  = (cal_hour[5:0] == 6'h23);
            first_hour = (cal_hour[5:0] == 6'h00);
        end else begin
            last_hour  = cal_hour[5] && (cal_hour[4:0] == 5'h11);
            first_hour = !cal_hour[5] && (cal_hour[4:0] == 5'h12);
        end
        go_fwd = top_of_hour && enable && !status_q && rule_hit[FWD_IDX] && !last_hour;
        go_rev = top_of_hour && enable &&  status_q && rule_hit[REV_IDX] && !first_hour;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (go_fwd) begin
                    state_d = ST_FWD;
                end else if (go_rev) begin
                    state_d = ST_REV;
                end
            end
            ST_FWD:  state_d = ST_IDLE;
            ST_REV:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        adj_fwd = 1'b0;
        adj_rev = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FWD:  adj_fwd = 1'b1;
            ST_REV:  adj_rev = 1'b1;
            default: ;
        endcase
    end

    // Shift status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q <= 1'b0;
        end else if (ena_clear) begin
            status_q <= 1'b0;
        end else if ((state_q == ST_IDLE) && (state_d == ST_FWD)) begin
            status_q <= 1'b1;
        end else if ((state_q == ST_IDLE) && (state_d == ST_REV)) begin
            status_q <= 1'b0;
        end
    end

    assign dst_active = status_q;

endmodule

// File: rtl/dst_adjuster_chk.sv
module dst_adjuster_chk
    import dst_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_wr_en,
    input logic [CFG_ADDR_W-1:0] cfg_addr,
    input logic [7:0]            cfg_wdata,
    input logic [7:0]            cal_min,
    input logic [7:0]            cal_sec,
    input logic                  sec_tick,
    input logic                  adj_fwd,
    input logic                  adj_rev,
    input logic                  dst_active
);

    assert_req_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(adj_fwd && adj_rev));

    assert_fwd_sets_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adj_fwd |-> dst_active);

    assert_fwd_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        adj_fwd |=> !adj_fwd);

    assert_rise_from_fwd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dst_active) |-> adj_fwd);

    assert_rev_clears_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adj_rev |-> !dst_active);

    assert_rev_needs_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        adj_rev |-> $past(dst_active));

    assert_fwd_needs_unshift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adj_fwd |-> !$past(dst_active));

    assert_fall_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dst_active) |-> (adj_rev ||
            $past(cfg_wr_en && (cfg_addr == '0) && !cfg_wdata[ENA_BIT])));

    assert_top_of_hour_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (adj_fwd || adj_rev) |-> $past(sec_tick && (cal_min == 8'h00) && (cal_sec == 8'h00)));

endmodule

bind dst_adjuster dst_adjuster_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_en  (cfg_wr_en),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cal_min    (cal_min),
    .cal_sec    (cal_sec),
    .sec_tick   (sec_tick),
    .adj_fwd    (adj_fwd),
    .adj_rev    (adj_rev),
    .dst_active (dst_active)
);

// File: tb/dst_adjuster_tb.sv
module dst_adjuster_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic [7:0] cal_year = 8'h24;
    logic [7:0] cal_month = 8'h01;
    logic [7:0] cal_date = 8'h01;
    logic [2:0] cal_wday = 3'd0;
    logic [7:0] cal_hour = 8'h00;
    logic [7:0] cal_min = 8'h00;
    logic [7:0] cal_sec = 8'h00;
    logic       sec_tick = 1'b0;
    logic       adj_fwd;
    logic       adj_rev;
    logic       dst_active;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  f;
        logic  r;
        logic  a;
        string tag;
    } exp_t;

    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dst_adjuster u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr_en  (cfg_wr_en),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .cal_year   (cal_year),
        .cal_month  (cal_month),
        .cal_date   (cal_date),
        .cal_wday   (cal_wday),
        .cal_hour   (cal_hour),
        .cal_min    (cal_min),
        .cal_sec    (cal_sec),
        .sec_tick   (sec_tick),
        .adj_fwd    (adj_fwd),
        .adj_rev    (adj_rev),
        .dst_active (dst_active)
    );

    task automatic check3(input logic [2:0] act, input logic [2:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {fwd,rev,active} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pops one expectation per tick and compares in the cycle after it
    initial begin
        forever begin
            @(posedge clk);
            if (sec_tick === 1'b1) begin
                @(negedge clk);
                if (sb.size() == 0) begin
                    checks++;
                    fails++;
                    $display("FAIL scoreboard: tick with no expectation, actual %b expected none",
                             {adj_fwd, adj_rev, dst_active});
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check3({adj_fwd, adj_rev, dst_active}, {e.f, e.r, e.a}, e.tag);
                    @(negedge clk);
                    check3({adj_fwd, adj_rev, dst_active}, {1'b0, 1'b0, e.a},
                           {e.tag, " pulse width"});
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [2:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check8(cfg_rdata, exp, tag);
    endtask

    task automatic do_tick(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                           input logic [2:0] wd, input logic [7:0] hr, input logic [7:0] mn,
                           input logic [7:0] sc, input logic ef, input logic er,
                           input logic ea, input string tag);
        exp_t e;
        @(negedge clk);
        cal_year  = yr;
        cal_month = mo;
        cal_date  = dt;
        cal_wday  = wd;
        cal_hour  = hr;
        cal_min   = mn;
        cal_sec   = sc;
        sec_tick  = 1'b1;
        e.f = ef; e.r = er; e.a = ea; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        sec_tick = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check3({adj_fwd, adj_rev, dst_active}, 3'b000, "R1 outputs after reset");
        rd_check(3'd0, 8'h04, "R1 addr0");
        rd_check(3'd1, 8'h00, "R1 addr1");
        rd_check(3'd2, 8'h01, "R1 addr2");
        rd_check(3'd3, 8'h02, "R1 addr3");
        rd_check(3'd4, 8'h10, "R1 addr4");
        rd_check(3'd5, 8'h00, "R1 addr5");
        rd_check(3'd6, 8'h01, "R1 addr6");
        rd_check(3'd7, 8'h02, "R1 addr7");

        // R2 masks
        wr(3'd0, 8'hFF); rd_check(3'd0, 8'h9F, "R2 addr0 mask");
        wr(3'd1, 8'hFF); rd_check(3'd1, 8'h7F, "R2 addr1 mask");
        wr(3'd2, 8'hFF); rd_check(3'd2, 8'h3F, "R2 addr2 mask");
        wr(3'd3, 8'hFF); rd_check(3'd3, 8'hBF, "R2 addr3 mask");
        wr(3'd4, 8'hFF); rd_check(3'd4, 8'h1F, "R2 addr4 mask");
        wr(3'd0, 8'h04); wr(3'd1, 8'h00); wr(3'd2, 8'h01); wr(3'd3, 8'h02); wr(3'd4, 8'h10);

        // R3 disabled: default spring rule matches but nothing happens
        do_tick(8'h24, 8'h04, 8'h01, 3'd0, 8'h02, 8'h00, 8'h00, 0, 0, 0, "R3 disabled no fwd");

        wr(3'd0, 8'h84);
        // R11 not at top of hour
        do_tick(8'h24, 8'h04, 8'h01, 3'd0, 8'h02, 8'h30, 8'h00, 0, 0, 0, "R11 minutes 30");
        do_tick(8'h24, 8'h04, 8'h01, 3'd0, 8'h02, 8'h00, 8'h05, 0, 0, 0, "R11 seconds 05");
        // R4 spring forward, date mode
        do_tick(8'h24, 8'h04, 8'h01, 3'd0, 8'h02, 8'h00, 8'h00, 1, 0, 1, "R4 fwd default rule");
        // R6 no second spring while shifted
        do_tick(8'h24, 8'h04, 8'h01, 3'd0, 8'h02, 8'h00, 8'h00, 0, 0, 1, "R6 fwd blocked");
        // R5 fall back and repeated hour
        do_tick(8'h24, 8'h10, 8'h01, 3'd0, 8'h02, 8'h00, 8'h00, 0, 1, 0, "R5 rev default rule");
        do_tick(8'h24, 8'h10, 8'h01, 3'd0, 8'h02, 8'h00, 8'h00, 0, 0, 0, "R5 repeated hour no rev");

        // R10 hour format flag
        wr(3'd3, 8'h82);
        do_tick(8'h24, 8'h04, 8'h01, 3'd0, 8'h02, 8'h00, 8'h00, 0, 0, 0, "R10 format mismatch");
        do_tick(8'h24, 8'h04, 8'h01, 3'd0, 8'h82, 8'h00, 8'h00, 1, 0, 1, "R10 format match");

        // R3 clearing enable drops status at once
        wr(3'd0, 8'h04);
        checks++;
        if (dst_active !== 1'b0) begin
            fails++;
            $display("FAIL R3 enable clear: actual %b expected 0", dst_active);
        end
        do_tick(8'h24, 8'h04, 8'h01, 3'd0, 8'h82, 8'h00, 8'h00, 0, 0, 0, "R3 disabled after clear");
        wr(3'd0, 8'h84);

        // R7 second Sunday
        wr(3'd1, 8'h50);
        do_tick(8'h24, 8'h04, 8'h01, 3'd0, 8'h82, 8'h00, 8'h00, 0, 0, 0, "R7 week1 ignored date byte");
        do_tick(8'h24, 8'h04, 8'h15, 3'd0, 8'h82, 8'h00, 8'h00, 0, 0, 0, "R7 week3 no match");
        do_tick(8'h24, 8'h04, 8'h08, 3'd1, 8'h82, 8'h00, 8'h00, 0, 0, 0, "R7 wrong weekday");
        do_tick(8'h24, 8'h04, 8'h08, 3'd0, 8'h82, 8'h00, 8'h00, 1, 0, 1, "R7 week2 sunday");
        do_tick(8'h24, 8'h10, 8'h01, 3'd0, 8'h02, 8'h00, 8'h00, 0, 1, 0, "R5 rev after R7");

        // R8 last Wednesday of February
        wr(3'd0, 8'h82);
        wr(3'd1, 8'h7B);
        do_tick(8'h24, 8'h02, 8'h22, 3'd3, 8'h82, 8'h00, 8'h00, 0, 0, 0, "R8 leap feb 22 not last");
        do_tick(8'h24, 8'h02, 8'h23, 3'd3, 8'h82, 8'h00, 8'h00, 1, 0, 1, "R8 leap feb 23 last");
        do_tick(8'h24, 8'h10, 8'h01, 3'd0, 8'h02, 8'h00, 8'h00, 0, 1, 0, "R8 rev");
        do_tick(8'h00, 8'h02, 8'h22, 3'd3, 8'h82, 8'h00, 8'h00, 0, 0, 0, "R8 year 00 leap");
        do_tick(8'h23, 8'h02, 8'h22, 3'd3, 8'h82, 8'h00, 8'h00, 1, 0, 1, "R8 nonleap feb 22 last");
        do_tick(8'h23, 8'h10, 8'h01, 3'd0, 8'h02, 8'h00, 8'h00, 0, 1, 0, "R8 rev again");

        // R9 week 0 and week 6
        wr(3'd1, 8'h43);
        do_tick(8'h23, 8'h02, 8'h22, 3'd3, 8'h82, 8'h00, 8'h00, 0, 0, 0, "R9 week0 off");
        wr(3'd1, 8'h73);
        do_tick(8'h23, 8'h02, 8'h01, 3'd3, 8'h82, 8'h00, 8'h00, 0, 0, 0, "R9 week6 off");

        // R12 rollover guards
        wr(3'd1, 8'h00);
        wr(3'd3, 8'hA3);
        do_tick(8'h23, 8'h02, 8'h01, 3'd0, 8'hA3, 8'h00, 8'h00, 0, 0, 0, "R12 fwd at 23h");
        wr(3'd3, 8'h31);
        do_tick(8'h23, 8'h02, 8'h01, 3'd0, 8'h31, 8'h00, 8'h00, 0, 0, 0, "R12 fwd at 11PM");
        wr(3'd3, 8'h82);
        do_tick(8'h23, 8'h02, 8'h01, 3'd0, 8'h82, 8'h00, 8'h00, 1, 0, 1, "R12 fwd at 02h ok");
        wr(3'd4, 8'h02);
        wr(3'd7, 8'h80);
        do_tick(8'h23, 8'h02, 8'h01, 3'd0, 8'h80, 8'h00, 8'h00, 0, 0, 1, "R12 rev at 00h");
        wr(3'd7, 8'h12);
        do_tick(8'h23, 8'h02, 8'h01, 3'd0, 8'h12, 8'h00, 8'h00, 0, 0, 1, "R12 rev at 12AM");
        wr(3'd7, 8'h82);
        do_tick(8'h23, 8'h02, 8'h01, 3'd0, 8'h82, 8'h00, 8'h00, 0, 1, 0, "R12 rev at 02h ok");

        repeat (4) @(negedge clk);
        if (sb.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule